// File: doc/BRIEF.md
# Load-Store Byte-Lane Aligner

This block sits between a processor core and a 32-bit data memory addressed by whole words. The core hands it an access opcode and an effective address. The address is already formed upstream as base register plus sign-extended 16-bit immediate. For stores the core also supplies the source register value, and for loads the memory supplies the read word. From these the block decodes the access size and signedness. It checks the low address bits for alignment. It then produces the word address, per-byte write enables, write data steered into the addressed lanes, and a load result that is extracted from the addressed lanes and extended to 32 bits.

Lanes are ordered big-endian: byte offset 0 within a word is data bits 31:24 and offset 3 is bits 7:0. A load result is captured on the clock edge that ends the load cycle and is then held. A misaligned access or an unrecognized opcode leaves the held result, and the memory, untouched.

Top module: `mem_lane_aligner`

## Requirements
- R1: After a synchronous active-high reset, `load_data` is 0. With `acc_valid` low, `mem_req`, `mem_write` and `mem_be` are all 0.
- R2: Opcode 0x23 with address bits 1:0 = 00 raises `mem_req` with `mem_write` = 0. `load_data` equals `mem_rdata` from the clock edge that ends that cycle.
- R3: Opcode 0x21 loads a halfword and sign-extends it; opcode 0x25 loads a halfword and zero-extends it. Address bit 1 = 0 selects `mem_rdata[31:16]` and bit 1 = 1 selects `mem_rdata[15:0]`.
- R4: Opcode 0x20 loads a byte and sign-extends it; opcode 0x24 loads a byte and zero-extends it. Byte offset k (address bits 1:0) selects `mem_rdata[31-8k:24-8k]`.
- R5: Opcode 0x2B with aligned address raises `mem_req` and `mem_write`, with `mem_be` = 4'b1111 and `mem_wdata` = `acc_store_data`.
- R6: Opcode 0x29 stores `acc_store_data[15:0]`. `mem_be` is 4'b1100 at address bit 1 = 0 and 4'b0011 at address bit 1 = 1. `mem_wdata` carries the halfword in both halves. `mem_be` bit i enables `mem_wdata[8i+7:8i]`.
- R7: Opcode 0x28 stores `acc_store_data[7:0]`. Byte offset k sets only `mem_be` bit 3-k, and `mem_wdata` carries the byte in all four lanes.
- R8: A halfword access with address bit 0 set, or a word access with either of address bits 1:0 set, raises `misaligned`. The access then forces `mem_req`, `mem_write` and `mem_be` to 0 and leaves `load_data` unchanged. Byte accesses are never misaligned.
- R9: An opcode outside {0x20, 0x21, 0x23, 0x24, 0x25, 0x28, 0x29, 0x2B}, or `acc_valid` low, gives `mem_req` = 0, `mem_be` = 0 and `misaligned` = 0, and leaves `load_data` unchanged.
- R10: `mem_word_addr` equals `acc_addr` with its two low bits dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_opcode | input | 6 | Primary opcode of the access |
| acc_addr | input | ADDR_W | Effective byte address |
| acc_store_data | input | 32 | Source register value for stores |
| mem_rdata | input | 32 | Word read from memory this cycle |
| mem_req | output | 1 | Legal access issued to memory |
| mem_write | output | 1 | Issued access is a store |
| mem_word_addr | output | ADDR_W-2 | Word address to memory |
| mem_be | output | 4 | Byte write enables, bit i for bits 8i+7:8i |
| mem_wdata | output | 32 | Lane-steered write data |
| load_data | output | 32 | Held, extended load result |
| misaligned | output | 1 | Access violates its natural alignment |

## Verification
The hardest case to reach is a rejected load: a misaligned or unknown access arriving right after a good load, while the memory presents a read word that differs from the held value. Only then would a wrongly enabled capture register show up as a change in `load_data`. The bench first loads a known word and then presents a misaligned word load, a misaligned halfword load and several unknown opcodes. During each of these `mem_rdata` is driven with a different pattern, and `load_data` is checked after the edge. Byte and halfword loads walk every offset over a read word whose lanes differ in sign bit, so that each wrong lane choice or wrong extension gives a distinct value.

// File: rtl/mla_pkg.sv
package mla_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int OFF_W  = $clog2(LANES);

    localparam logic [5:0] OPC_LB  = 6'h20;
    localparam logic [5:0] OPC_LH  = 6'h21;
    localparam logic [5:0] OPC_LW  = 6'h23;
    localparam logic [5:0] OPC_LBU = 6'h24;
    localparam logic [5:0] OPC_LHU = 6'h25;
    localparam logic [5:0] OPC_SB  = 6'h28;
    localparam logic [5:0] OPC_SH  = 6'h29;
    localparam logic [5:0] OPC_SW  = 6'h2B;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic      known;
        logic      store;
        logic      sext;
        acc_size_e size;
    } acc_ctrl_t;

    function automatic acc_ctrl_t decode_op(input logic [5:0] op);
        acc_ctrl_t c;
        c = '{known: 1'b1, store: 1'b0, sext: 1'b0, size: SZ_WORD};
        case (op)
            OPC_LB:  begin c.size = SZ_BYTE; c.sext = 1'b1; end
            OPC_LBU: c.size = SZ_BYTE;
            OPC_LH:  begin c.size = SZ_HALF; c.sext = 1'b1; end
            OPC_LHU: c.size = SZ_HALF;
            OPC_LW:  c.size = SZ_WORD;
            OPC_SB:  begin c.size = SZ_BYTE; c.store = 1'b1; end
            OPC_SH:  begin c.size = SZ_HALF; c.store = 1'b1; end
            OPC_SW:  begin c.size = SZ_WORD; c.store = 1'b1; end
            default: c.known = 1'b0;
        endcase
        return c;
    endfunction

    function automatic logic off_bad(input acc_size_e sz, input logic [OFF_W-1:0] off);
        case (sz)
            SZ_HALF: return off[0];
            SZ_WORD: return |off;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mla_decode.sv
module mla_decode
    import mla_pkg::*;
(
    input  logic       valid,
    input  logic [5:0] opcode,
    output acc_ctrl_t  ctrl
);
    acc_ctrl_t raw;

    always_comb begin
        raw        = decode_op(opcode);
        ctrl       = raw;
        ctrl.known = raw.known & valid;
    end
endmodule

// File: rtl/mla_align_check.sv
module mla_align_check
    import mla_pkg::*;
(
    input  acc_ctrl_t        ctrl,
    input  logic [OFF_W-1:0] offset,
    output logic             misaligned,
    output logic             issue
);
    always_comb begin
        misaligned = ctrl.known & off_bad(ctrl.size, offset);
        issue      = ctrl.known & ~misaligned;
    end
endmodule

// File: rtl/mla_store_steer.sv
module mla_store_steer
    import mla_pkg::*;
(
    input  acc_ctrl_t         ctrl,
    input  logic              issue,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] src,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_OFF = OFF_W'(LANES - 1 - i);
        logic hit;

        always_comb begin
            case (ctrl.size)
                SZ_BYTE: hit = (LANE_OFF == offset);
                SZ_HALF: hit = (LANE_OFF[OFF_W-1:1] == offset[OFF_W-1:1]);
                default: hit = 1'b1;
            endcase
            be[i] = issue & ctrl.store & hit;

            case (ctrl.size)
                SZ_BYTE: wdata[8*i +: 8] = src[7:0];
                SZ_HALF: wdata[8*i +: 8] = LANE_OFF[0] ? src[7:0] : src[15:8];
                default: wdata[8*i +: 8] = src[8*i +: 8];
            endcase
        end
    end
endmodule

// File: rtl/mla_load_extract.sv
module mla_load_extract
    import mla_pkg::*;
(
    input  acc_ctrl_t         ctrl,
    input  logic [OFF_W-1:0]  offset,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    always_comb begin
        byte_sel = rdata[8*(LANES-1-int'(offset)) +: 8];
        half_sel = offset[1] ? rdata[15:0] : rdata[31:16];
        case (ctrl.size)
            SZ_BYTE: result = {{(DATA_W-8){ctrl.sext & byte_sel[7]}}, byte_sel};
            SZ_HALF: result = {{(DATA_W-16){ctrl.sext & half_sel[15]}}, half_sel};
            default: result = rdata;
        endcase
    end
endmodule

// File: rtl/mem_lane_aligner.sv
module mem_lane_aligner
    import mla_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [5:0]        acc_opcode,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_store_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-3:0] mem_word_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] load_data,
    output logic              misaligned
);
    acc_ctrl_t         ctrl;
    logic              issue;
    logic [OFF_W-1:0]  offset;
    logic [DATA_W-1:0] extracted;
    logic [DATA_W-1:0] load_q;

    assign offset        = acc_addr[OFF_W-1:0];
    assign mem_word_addr = acc_addr[ADDR_W-1:OFF_W];

    mla_decode u_decode (
        .valid  (acc_valid),
        .opcode (acc_opcode),
        .ctrl   (ctrl)
    );

    mla_align_check u_align (
        .ctrl       (ctrl),
        .offset     (offset),
        .misaligned (misaligned),
        .issue      (issue)
    );

    mla_store_steer u_steer (
        .ctrl   (ctrl),
        .issue  (issue),
        .offset (offset),
        .src    (acc_store_data),
        .be     (mem_be),
        .wdata  (mem_wdata)
    );

    mla_load_extract u_extract (
        .ctrl   (ctrl),
        .offset (offset),
        .rdata  (mem_rdata),
        .result (extracted)
    );

    assign mem_req   = issue;
    assign mem_write = issue & ctrl.store;

    always_ff @(posedge clk) begin
        if (rst)
            load_q <= '0;
        else if (issue && !ctrl.store)
            load_q <= extracted;
    end

    assign load_data = load_q;

    AST_RESET_CLEAR: assert property (@(posedge clk) $fell(rst) |-> load_data == '0); // R1
    AST_WORD_LOAD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_write && acc_opcode == OPC_LW) |=> load_data == $past(mem_rdata)); // R2
    AST_STORE_LANES: assert property (@(posedge clk) disable iff (rst)
        mem_write |-> mem_be != '0); // R5
    AST_HALF_PAIR: assert property (@(posedge clk) disable iff (rst)
        (mem_write && acc_opcode == OPC_SH) |-> (mem_be == 4'b1100 || mem_be == 4'b0011)); // R6
    AST_BYTE_ONE: assert property (@(posedge clk) disable iff (rst)
        (mem_write && acc_opcode == OPC_SB) |-> $countones(mem_be) == 1); // R7
    AST_MISALIGN_QUIET: assert property (@(posedge clk) disable iff (rst)
        misaligned |-> (mem_be == '0 && !mem_req && !mem_write)); // R8
    AST_NO_LOAD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && !mem_write) |=> $stable(load_data)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (!mem_req && mem_be == '0 && !misaligned)); // R9

endmodule

// File: tb/mem_lane_aligner_tb.sv
module mem_lane_aligner_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [5:0]  acc_opcode = '0;
    logic [31:0] acc_addr = '0;
    logic [31:0] acc_store_data = '0;
    logic [31:0] mem_rdata = '0;
    logic        mem_req, mem_write, misaligned;
    logic [29:0] mem_word_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, load_data;

    int nchecks = 0;
    int nfail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_lane_aligner u_dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_opcode(acc_opcode),
        .acc_addr(acc_addr), .acc_store_data(acc_store_data), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_write(mem_write), .mem_word_addr(mem_word_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .load_data(load_data),
        .misaligned(misaligned)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Present an access on a falling edge, then sample the outputs 1 time unit later.
    task automatic present(input logic [5:0] op, input logic [31:0] addr,
                           input logic [31:0] sd, input logic [31:0] rd);
        @(negedge clk);
        acc_valid = 1'b1; acc_opcode = op; acc_addr = addr;
        acc_store_data = sd; mem_rdata = rd;
        #1;
    endtask

    // Let the rising edge pass, then sample after it.
    task automatic finish_cycle();
        @(posedge clk); #1;
        acc_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 load_data after reset", load_data, 32'h0);
        check("R1 mem_req idle", {31'b0, mem_req}, 32'h0);
        check("R1 mem_write idle", {31'b0, mem_write}, 32'h0);
        check("R1 mem_be idle", {28'b0, mem_be}, 32'h0);
    endtask

    task automatic t_word_load();
        present(8'h23, 32'h0000_0104, 32'h0, 32'hDEAD_BEEF);
        check("R2 mem_req", {31'b0, mem_req}, 32'h1);
        check("R2 mem_write", {31'b0, mem_write}, 32'h0);
        check("R10 word addr", {2'b0, mem_word_addr}, 32'h0000_0041);
        finish_cycle();
        check("R2 load_data", load_data, 32'hDEAD_BEEF);
    endtask

    task automatic t_half_loads();
        logic [31:0] rd = 32'h8001_7FFE;
        present(6'h21, 32'h0000_0200, 32'h0, rd); finish_cycle();
        check("R3 lh off0", load_data, 32'hFFFF_8001);
        present(6'h25, 32'h0000_0200, 32'h0, rd); finish_cycle();
        check("R3 lhu off0", load_data, 32'h0000_8001);
        present(6'h21, 32'h0000_0202, 32'h0, rd); finish_cycle();
        check("R3 lh off2", load_data, 32'h0000_7FFE);
        present(6'h25, 32'h0000_0202, 32'h0, 32'h1234_F00D); finish_cycle();
        check("R3 lhu off2", load_data, 32'h0000_F00D);
        present(6'h21, 32'h0000_0202, 32'h0, 32'h1234_F00D); finish_cycle();
        check("R3 lh off2 neg", load_data, 32'hFFFF_F00D);
    endtask

    task automatic t_byte_loads();
        logic [31:0] rd = 32'h807F_C301;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] b;
            b = 8'((rd >> (8*(3-k))) & 32'hFF);
            present(6'h20, 32'h0000_0300 + k, 32'h0, rd); finish_cycle();
            check($sformatf("R4 lb off%0d", k), load_data, {{24{b[7]}}, b});
            present(6'h24, 32'h0000_0300 + k, 32'h0, rd); finish_cycle();
            check($sformatf("R4 lbu off%0d", k), load_data, {24'h0, b});
        end
    endtask

    task automatic t_word_store();
        present(6'h2B, 32'h0000_0400, 32'hCAFE_1234, 32'h0);
        check("R5 req/write", {30'b0, mem_req, mem_write}, 32'h3);
        check("R5 be", {28'b0, mem_be}, 32'hF);
        check("R5 wdata", mem_wdata, 32'hCAFE_1234);
        finish_cycle();
    endtask

    task automatic t_half_store();
        present(6'h29, 32'h0000_0500, 32'hAAAA_BEEF, 32'h0);
        check("R6 be off0", {28'b0, mem_be}, 32'hC);
        check("R6 wdata off0", mem_wdata, 32'hBEEF_BEEF);
        check("R6 write", {31'b0, mem_write}, 32'h1);
        finish_cycle();
        present(6'h29, 32'h0000_0502, 32'h5555_1357, 32'h0);
        check("R6 be off2", {28'b0, mem_be}, 32'h3);
        check("R6 wdata off2", mem_wdata, 32'h1357_1357);
        finish_cycle();
    endtask

    task automatic t_byte_store();
        for (int k = 0; k < 4; k++) begin
            present(6'h28, 32'h0000_0600 + k, 32'h1234_56A5, 32'h0);
            check($sformatf("R7 be off%0d", k), {28'b0, mem_be}, 32'(1 << (3-k)));
            check($sformatf("R7 wdata off%0d", k), mem_wdata, 32'hA5A5_A5A5);
            check($sformatf("R8 byte never misaligned off%0d", k), {31'b0, misaligned}, 32'h0);
            finish_cycle();
        end
    endtask

    task automatic t_misaligned();
        present(6'h23, 32'h0000_0700, 32'h0, 32'h0BAD_F00D); finish_cycle();
        check("R8 prime load", load_data, 32'h0BAD_F00D);
        present(6'h23, 32'h0000_0702, 32'h0, 32'h1111_2222);
        check("R8 lw misaligned flag", {31'b0, misaligned}, 32'h1);
        check("R8 lw no req", {31'b0, mem_req}, 32'h0);
        finish_cycle();
        check("R8 lw hold", load_data, 32'h0BAD_F00D);
        present(6'h21, 32'h0000_0703, 32'h0, 32'h3333_4444); finish_cycle();
        check("R8 lh hold", load_data, 32'h0BAD_F00D);
        present(6'h2B, 32'h0000_0701, 32'hFFFF_FFFF, 32'h0);
        check("R8 sw misaligned flag", {31'b0, misaligned}, 32'h1);
        check("R8 sw no be", {27'b0, mem_req, mem_be}, 32'h0);
        check("R8 sw no write", {31'b0, mem_write}, 32'h0);
        finish_cycle();
        present(6'h29, 32'h0000_0701, 32'hFFFF_FFFF, 32'h0);
        check("R8 sh no be", {28'b0, mem_be}, 32'h0);
        check("R8 sh flag", {31'b0, misaligned}, 32'h1);
        finish_cycle();
    endtask

    task automatic t_ignored();
        logic [5:0] ops [4] = '{6'h22, 6'h00, 6'h2A, 6'h3F};
        for (int i = 0; i < 4; i++) begin
            present(ops[i], 32'h0000_0800, 32'hFFFF_FFFF, 32'h7777_7777);
            check($sformatf("R9 op %02h quiet", ops[i]),
                  {26'b0, mem_req, mem_write, mem_be}, 32'h0);
            check($sformatf("R9 op %02h no flag", ops[i]), {31'b0, misaligned}, 32'h0);
            finish_cycle();
            check($sformatf("R9 op %02h hold", ops[i]), load_data, 32'h0BAD_F00D);
        end
        present(6'h23, 32'h0000_0900, 32'h0, 32'h9999_9999);
        acc_valid = 1'b0; #1;
        check("R9 valid low quiet", {31'b0, mem_req}, 32'h0);
        finish_cycle();
        check("R9 valid low hold", load_data, 32'h0BAD_F00D);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_word_load();
        t_half_loads();
        t_byte_loads();
        t_word_store();
        t_half_store();
        t_byte_store();
        t_misaligned();
        t_ignored();
        done = 1;
        summary();
        $finish;
    end
endmodule